// File: doc/BRIEF.md
# Preemptive DMA Channel Scheduler

This block selects which DMA channel the loop sequencer serves next and tracks where that channel's descriptor is held. Each channel raises a level request. The block compares the pending requests by a configured priority number, one per channel. It then asks local memory to load the winner's descriptor into one of two descriptor register sets, x (set 0) and y (set 1). When the load is finished, it tells the sequencer to run that channel from that set.

The sequencer reports each completed read/write sequence, and marks the last sequence of a minor loop. A running channel can be suspended at such a boundary, and only at such a boundary. This happens only when its preemption-enable bit is set and a channel with a higher priority number is waiting. The suspended context stays in its register set. The preempting channel loads into the other set and cannot itself be suspended. When the preempting channel finishes its minor loop, the suspended channel runs again at once from the register set it kept, and its descriptor is not loaded again.

Top module: `dma_preempt_sched`

## Requirements
- R1: After reset, ld_req_o, run_o and sus_o are all 0.
- R2: When the block is idle, the eligible request with the highest priority number wins. The block raises ld_req_o with ld_ch_o set to the winner and ld_set_o set to 0 (set x) on the clock edge after the request is seen.
- R3: On the edge where ld_done_i is sampled high during a load, ld_req_o falls and run_o rises. run_ch_o and run_set_o show the loaded channel and its set.
- R4: A boundary is a cycle with seq_done_i=1 and last_i=0 while the block is running and not nested. If, at a boundary, the running channel's preempt_en_i bit is 1 and a waiting channel has a higher priority number, the next cycle shows run_o=0, ld_req_o=1, the preempting channel on ld_ch_o, the other set on ld_set_o, sus_o=1, and the suspended channel on sus_ch_o.
- R5: A higher-priority request that arrives while no sequence boundary is reported does not interrupt the running channel.
- R6: A running channel whose preempt_en_i bit is 0 is never preempted and keeps running until its minor loop ends.
- R7: A waiting request whose priority number is lower than the running channel's does not preempt it.
- R8: A channel that preempted another one cannot be preempted itself, even by a higher-priority request at a boundary.
- R9: When the preempting channel signals the end of its loop (seq_done_i=1, last_i=1), the next cycle shows run_o=1 with the suspended channel and its original set, sus_o=0, and no load request.
- R10: A channel that is running or suspended is not granted again. If it still requests after its loop ends, it is granted again.
- R11: When a loop ends and no channel is suspended, run_o falls, and arbitration restarts on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_CH | Per-channel service request (level) |
| prio_i | input | N_CH*PRIO_W | Per-channel priority number, packed by channel index, all values unique |
| preempt_en_i | input | N_CH | Per-channel permission to be preempted |
| ld_req_o | output | 1 | Descriptor load request to local memory |
| ld_ch_o | output | CH_W | Channel whose descriptor is to be loaded |
| ld_set_o | output | 1 | Target register set (0 = x, 1 = y) |
| ld_done_i | input | 1 | Descriptor load finished |
| run_o | output | 1 | Sequencer may run the active channel |
| run_ch_o | output | CH_W | Active channel |
| run_set_o | output | 1 | Register set of the active channel |
| seq_done_i | input | 1 | A read/write sequence has completed |
| last_i | input | 1 | Qualifies seq_done_i: it was the last sequence of the minor loop |
| sus_o | output | 1 | A channel is held suspended |
| sus_ch_o | output | CH_W | Suspended channel |

## Verification
The hardest case to reach is the resume path. It needs a suspended low-priority channel, a preempting channel that is itself offered a higher request it must refuse, and then a loop end that switches sets without a load. The stimulus starts the lowest-priority channel and preempts it with a mid-priority channel. It then raises the top-priority request during the nested run and pulses a boundary, which must not preempt. Finally it ends the nested loop and checks that the suspended channel resumes and can then be preempted by the request that is still pending.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } sched_st_e;
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 3,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]        req_i,
  input  logic [N_CH*PRIO_W-1:0] prio_i,
  input  logic [N_CH-1:0]        busy_i,
  output logic                   win_vld_o,
  output logic [CH_W-1:0]        win_ch_o,
  output logic [PRIO_W-1:0]      win_prio_o
);
  always_comb begin
    win_vld_o  = 1'b0;
    win_ch_o   = '0;
    win_prio_o = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (req_i[c] && !busy_i[c] &&
          (!win_vld_o || prio_i[c*PRIO_W +: PRIO_W] > win_prio_o)) begin
        win_vld_o  = 1'b1;
        win_ch_o   = CH_W'(c);
        win_prio_o = prio_i[c*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/dma_ctx_sets.sv
module dma_ctx_sets #(
  parameter int N_CH  = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  alloc_i,
  input  logic                  alloc_set_i,
  input  logic [CH_W-1:0]       alloc_ch_i,
  input  logic                  free_i,
  input  logic                  free_set_i,
  output logic [1:0]            set_vld_o,
  output logic [1:0][CH_W-1:0]  set_ch_o,
  output logic [N_CH-1:0]       busy_o
);
  for (genvar s = 0; s < 2; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_vld_o[s] <= 1'b0;
        set_ch_o[s]  <= '0;
      end else if (alloc_i && alloc_set_i == 1'(s)) begin
        set_vld_o[s] <= 1'b1;
        set_ch_o[s]  <= alloc_ch_i;
      end else if (free_i && free_set_i == 1'(s)) begin
        set_vld_o[s] <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_busy
    assign busy_o[c] = (set_vld_o[0] && set_ch_o[0] == CH_W'(c)) ||
                       (set_vld_o[1] && set_ch_o[1] == CH_W'(c));
  end

  // a load only ever targets a set that holds no context
  p_alloc_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !set_vld_o[alloc_set_i]);
  p_free_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> set_vld_o[free_set_i]);
  p_no_regrant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !busy_o[alloc_ch_i]);
endmodule

// File: rtl/dma_preempt_sched.sv
module dma_preempt_sched
  import dma_sched_pkg::*;
#(
  parameter int N_CH   = 8,
  parameter int PRIO_W = 3,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        req_i,
  input  logic [N_CH*PRIO_W-1:0] prio_i,
  input  logic [N_CH-1:0]        preempt_en_i,
  output logic                   ld_req_o,
  output logic [CH_W-1:0]        ld_ch_o,
  output logic                   ld_set_o,
  input  logic                   ld_done_i,
  output logic                   run_o,
  output logic [CH_W-1:0]        run_ch_o,
  output logic                   run_set_o,
  input  logic                   seq_done_i,
  input  logic                   last_i,
  output logic                   sus_o,
  output logic [CH_W-1:0]        sus_ch_o
);
  sched_st_e st_q, st_d;
  logic      act_set_q, act_set_d;

  logic [1:0]           set_vld;
  logic [1:0][CH_W-1:0] set_ch;
  logic [N_CH-1:0]      busy;
  logic                 win_vld;
  logic [CH_W-1:0]      win_ch;
  logic [PRIO_W-1:0]    win_prio;

  logic                 alloc, alloc_set, free, free_set;
  logic [CH_W-1:0]      alloc_ch;

  logic                 oth_set, nested;
  logic [CH_W-1:0]      act_ch, sus_ch;
  logic [PRIO_W-1:0]    act_prio;
  logic                 boundary, loop_end, preempt_ok;

  dma_prio_arb #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_arb (
    .req_i      (req_i),
    .prio_i     (prio_i),
    .busy_i     (busy),
    .win_vld_o  (win_vld),
    .win_ch_o   (win_ch),
    .win_prio_o (win_prio)
  );

  dma_ctx_sets #(.N_CH(N_CH)) u_ctx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc),
    .alloc_set_i (alloc_set),
    .alloc_ch_i  (alloc_ch),
    .free_i      (free),
    .free_set_i  (free_set),
    .set_vld_o   (set_vld),
    .set_ch_o    (set_ch),
    .busy_o      (busy)
  );

  assign oth_set  = ~act_set_q;
  assign act_ch   = set_ch[act_set_q];
  assign sus_ch   = set_ch[oth_set];
  assign nested   = set_vld[oth_set];
  assign act_prio = prio_i[int'(act_ch)*PRIO_W +: PRIO_W];

  assign boundary   = (st_q == ST_RUN) && seq_done_i && !last_i;
  assign loop_end   = (st_q == ST_RUN) && seq_done_i && last_i;
  // one level of nesting only; the victim must allow it and be outranked
  assign preempt_ok = boundary && !nested && preempt_en_i[act_ch] &&
                      win_vld && (win_prio > act_prio);

  always_comb begin
    st_d      = st_q;
    act_set_d = act_set_q;
    alloc     = 1'b0;
    alloc_set = 1'b0;
    alloc_ch  = win_ch;
    free      = 1'b0;
    free_set  = act_set_q;
    unique case (st_q)
      ST_IDLE: if (win_vld) begin
        alloc     = 1'b1;
        alloc_set = 1'b0;
        act_set_d = 1'b0;
        st_d      = ST_LOAD;
      end
      ST_LOAD: if (ld_done_i) st_d = ST_RUN;
      ST_RUN: begin
        if (loop_end) begin
          free = 1'b1;
          if (nested) act_set_d = oth_set;
          else        st_d      = ST_IDLE;
        end else if (preempt_ok) begin
          alloc     = 1'b1;
          alloc_set = oth_set;
          act_set_d = oth_set;
          st_d      = ST_LOAD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      act_set_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      act_set_q <= act_set_d;
    end
  end

  assign ld_req_o  = (st_q == ST_LOAD);
  assign ld_ch_o   = act_ch;
  assign ld_set_o  = act_set_q;
  assign run_o     = (st_q == ST_RUN);
  assign run_ch_o  = act_ch;
  assign run_set_o = act_set_q;
  assign sus_o     = (st_q != ST_IDLE) && nested;
  assign sus_ch_o  = sus_ch;

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_req_o && run_o));
  p_load_to_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_o && ld_done_i) |=> (run_o && $stable(run_ch_o)));
  p_at_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sus_o) |-> ($past(seq_done_i) && !$past(last_i)));
  p_enable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && seq_done_i && !last_i && !preempt_en_i[run_ch_o])
      |=> (run_o && $stable(run_ch_o)));
  p_outranks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_req_o && $rose(sus_o)) |->
      (prio_i[int'(ld_ch_o)*PRIO_W +: PRIO_W] > prio_i[int'(sus_ch_o)*PRIO_W +: PRIO_W]));
  p_one_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && sus_o && seq_done_i && !last_i) |=> run_o);
  p_resume_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && sus_o && seq_done_i && last_i)
      |=> (run_o && !ld_req_o && run_ch_o == $past(sus_ch_o)));
endmodule

// File: tb/tb_dma_preempt_sched.sv
module tb_dma_preempt_sched;
  localparam int N_CH = 8, PRIO_W = 3, CH_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_CH-1:0] req = '0, pen = '1;
  logic [N_CH*PRIO_W-1:0] prio;
  logic ld_done = 1'b0, seq_done = 1'b0, last = 1'b0;
  logic ld_req, ld_set, run, run_set, sus;
  logic [CH_W-1:0] ld_ch, run_ch, sus_ch;
  int total = 0, bad = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  // priority number of channel c is (3*c) mod 8: ch5=7 ch2=6 ch7=5 ch4=4 ch1=3 ch6=2 ch3=1 ch0=0
  for (genvar c = 0; c < N_CH; c++) begin : g_prio
    assign prio[c*PRIO_W +: PRIO_W] = PRIO_W'((3 * c) % 8);
  end

  dma_preempt_sched #(.N_CH(N_CH), .PRIO_W(PRIO_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .prio_i(prio), .preempt_en_i(pen),
    .ld_req_o(ld_req), .ld_ch_o(ld_ch), .ld_set_o(ld_set), .ld_done_i(ld_done),
    .run_o(run), .run_ch_o(run_ch), .run_set_o(run_set),
    .seq_done_i(seq_done), .last_i(last), .sus_o(sus), .sus_ch_o(sus_ch)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse(bit l);
    seq_done = 1'b1; last = l;
    cyc();
    seq_done = 1'b0; last = 1'b0;
  endtask

  task automatic expect_load(string tag, int ch, int set);
    chk({tag, " ld_req"}, ld_req, 1);
    chk({tag, " ld_ch"}, ld_ch, ch);
    chk({tag, " ld_set"}, ld_set, set);
    chk({tag, " run"}, run, 0);
  endtask

  task automatic finish_load(string tag, int ch, int set);
    ld_done = 1'b1;
    cyc();
    ld_done = 1'b0;
    chk({tag, " run"}, run, 1);
    chk({tag, " ld_req"}, ld_req, 0);
    chk({tag, " run_ch"}, run_ch, ch);
    chk({tag, " run_set"}, run_set, set);
  endtask

  task automatic t_reset();
    chk("R1 ld_req", ld_req, 0);
    chk("R1 run", run, 0);
    chk("R1 sus", sus, 0);
  endtask

  task automatic t_arbitrate();
    req = 8'b1000_1011;  // ch7, ch3, ch1, ch0
    cyc();
    expect_load("R2", 7, 0);
    req[7] = 1'b0;
    finish_load("R3", 7, 0);
    pulse(1'b1);
    chk("R11 run", run, 0);
    chk("R11 ld_req", ld_req, 0);
    cyc();
    expect_load("R11 next", 1, 0);
    req = '0;
    finish_load("R11 next", 1, 0);
    pulse(1'b1);
    cyc();
    chk("R11 idle", ld_req, 0);
  endtask

  task automatic t_lower_and_self();
    req[3] = 1'b1; req[0] = 1'b1;
    cyc();
    expect_load("R2 low", 3, 0);
    finish_load("R2 low", 3, 0);
    pulse(1'b0);
    chk("R7 run", run, 1);
    chk("R7 run_ch", run_ch, 3);
    chk("R10 ld_req", ld_req, 0);
    pulse(1'b1);
    cyc();
    expect_load("R10 regrant", 3, 0);
    req[3] = 1'b0;
    finish_load("R10 regrant", 3, 0);
    pulse(1'b1);
    cyc();
    expect_load("R10 after", 0, 0);
    req[0] = 1'b0;
    finish_load("R10 after", 0, 0);
    pulse(1'b1);
    cyc();
  endtask

  task automatic t_preempt_nest();
    req[0] = 1'b1;
    cyc();
    req[0] = 1'b0;
    finish_load("R4 base", 0, 0);
    req[4] = 1'b1;
    cyc();
    chk("R5 run", run, 1);
    chk("R5 run_ch", run_ch, 0);
    pulse(1'b0);
    expect_load("R4", 4, 1);
    chk("R4 sus", sus, 1);
    chk("R4 sus_ch", sus_ch, 0);
    req[4] = 1'b0;
    finish_load("R4", 4, 1);
    req[5] = 1'b1;
    pulse(1'b0);
    chk("R8 run", run, 1);
    chk("R8 run_ch", run_ch, 4);
    chk("R8 ld_req", ld_req, 0);
    pulse(1'b1);
    chk("R9 run", run, 1);
    chk("R9 run_ch", run_ch, 0);
    chk("R9 run_set", run_set, 0);
    chk("R9 ld_req", ld_req, 0);
    chk("R9 sus", sus, 0);
    pulse(1'b0);
    expect_load("R4 again", 5, 1);
    chk("R4 again sus_ch", sus_ch, 0);
    req[5] = 1'b0;
    finish_load("R4 again", 5, 1);
    pulse(1'b1);
    chk("R9 again run_ch", run_ch, 0);
    pulse(1'b1);
    chk("R11 end run", run, 0);
    cyc();
  endtask

  task automatic t_disabled();
    pen = ~8'b0000_0010;
    req[1] = 1'b1;
    cyc();
    req[1] = 1'b0;
    finish_load("R6 base", 1, 0);
    req[5] = 1'b1;
    pulse(1'b0);
    chk("R6 run_ch", run_ch, 1);
    pulse(1'b0);
    chk("R6 run", run, 1);
    chk("R6 sus", sus, 0);
    pulse(1'b1);
    chk("R6 end", run, 0);
    cyc();
    expect_load("R6 next", 5, 0);
    req[5] = 1'b0;
    finish_load("R6 next", 5, 0);
    pulse(1'b1);
    cyc();
    pen = '1;
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_arbitrate();
    t_lower_and_self();
    t_preempt_nest();
    t_disabled();
    if (!fin) begin
      fin = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule